// File: doc/BRIEF.md
# Forced Commutation Start-up Sequencer

This block brings a sensorless brushless motor from standstill to a known commutation rate. When the start command rises, it captures its configuration. It then holds the rotor in the first commutation step for a programmed alignment time, at a programmed holding torque. After that it drives the six-step commutation state open loop. The first commutation interval is a programmed length, and every later interval is shorter than the one before it by a fixed programmed decrement. The ramp stops when the next interval would reach the programmed final length. At that point the sequencer parks in a finished state and raises a done flag, so that closed-loop control can take over.

Time is measured only in ticks of an external timebase, one tick per 200 us. The 2 ms alignment base is counted as 10 ticks, and every 8 ms unit as 40 ticks. The torque demand is a 4-bit value in 6.25 % steps. A flag goes with it to say whether the value is a duty cycle or a current limit. PWM generation and back-EMF sensing are done by other blocks.

Top module: `fcs_startup_seq`

## Requirements
- R1: While reset is high, and on the first edge after it, the sequencer is idle (state code 0) with step 0, torque 0, mode flag 0 and done 0. The state codes are idle 0, hold 1, ramp 2, finished 3.
- R2: In idle with start high, the next clock edge moves the state to hold (1).
- R3: Hold lasts 10 + 40*HT ticks, where HT is hold_time_i. On the tick that completes the hold, the state leaves hold.
- R4: The first ramp interval lasts 40*SC ticks, where SC is start_per_i. At the end of each interval the step output advances by one, counting 0,1,2,3,4,5,0.
- R5: Each later ramp interval is shorter than the one before it by RR ticks, where RR is step_i.
- R6: When an interval ends and its length minus RR is no greater than EC ticks (EC is end_per_i), the step still advances. The state then becomes finished, done_o rises, and the step stays frozen.
- R7: If RR is 0, or if 40*SC is no greater than EC, the end of hold leads straight to finished with step 0.
- R8: The torque output is 0 in idle, the hold-torque field in hold, and the ramp-torque field in ramp and finished. The mode flag (1 = duty cycle, 0 = current) equals the captured mode bit outside idle and is 0 in idle.
- R9: Start low forces idle at the next edge from any state, with step 0, torque 0 and done 0.
- R10: Timers advance only on clock edges where tick_i is high. Without ticks, the state and step do not change.
- R11: All configuration inputs are captured on the idle-to-hold edge. Changes made to them while the sequencer is active have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command; low aborts to idle |
| tick_i | input | 1 | 200 us timebase strobe |
| hold_time_i | input | 4 | Alignment time code HT |
| hold_trq_i | input | 4 | Alignment torque code |
| ramp_trq_i | input | 4 | Ramp torque code |
| trq_is_duty_i | input | 1 | 1: torque is a duty cycle, 0: a current limit |
| start_per_i | input | 4 | First interval code SC (x40 ticks) |
| end_per_i | input | 4 | Final interval EC in ticks |
| step_i | input | 4 | Interval decrement RR in ticks |
| state_o | output | 2 | Sequencer state code |
| phase_o | output | 3 | Commutation step 0..5 |
| trq_o | output | 4 | Torque demand code |
| trq_duty_o | output | 1 | Torque mode flag |
| done_o | output | 1 | Ramp finished |

## Verification
The properties assume a sensible order of control. Reset is applied before start is raised. Start is the only way back to idle, so the step can only move forward by one inside a ramp, or fall to zero on an abort. The stimulus raises start only from idle, changes configuration only while the sequencer is active (to test capture) or while idle, and runs the timebase in three patterns: every cycle, every other cycle, and stalled. A behavioural model in the bench tracks the expected state, step and torque on every clock. Directed checks then confirm total ramp durations that are worked out independently from the interval series.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam int CFG_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_RAMP = 2'd2,
    ST_DONE = 2'd3
  } fcs_state_e;

  typedef struct packed {
    logic [CFG_W-1:0] hold_time;
    logic [CFG_W-1:0] hold_trq;
    logic [CFG_W-1:0] ramp_trq;
    logic [CFG_W-1:0] start_per;
    logic [CFG_W-1:0] end_per;
    logic [CFG_W-1:0] step;
    logic             is_duty;
  } fcs_cfg_t;

endpackage

// File: rtl/fcs_tick_timer.sv
module fcs_tick_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc  = cnt_q + 1'b1;
  assign expire_o = run && (cnt_inc == limit);

  always_ff @(posedge clk) begin
    if (rst || clr || expire_o) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= cnt_inc;
    end
  end

endmodule

// File: rtl/fcs_phase_ctr.sv
module fcs_phase_ctr #(
  parameter int PHASES = 6,
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            adv,
  output logic [PH_W-1:0] phase_o
);

  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase_o <= '0;
    end else if (adv) begin
      phase_o <= (phase_o == LAST) ? '0 : phase_o + 1'b1;
    end
  end

endmodule

// File: rtl/fcs_torque_out.sv
module fcs_torque_out
  import fcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  fcs_state_e       state_nxt,
  input  logic [CFG_W-1:0] hold_trq,
  input  logic [CFG_W-1:0] ramp_trq,
  input  logic             is_duty,
  output logic [CFG_W-1:0] trq_o,
  output logic             trq_duty_o,
  output logic             done_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      trq_o      <= '0;
      trq_duty_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= (state_nxt == ST_DONE);
      unique case (state_nxt)
        ST_IDLE: begin
          trq_o      <= '0;
          trq_duty_o <= 1'b0;
        end
        ST_HOLD: begin
          trq_o      <= hold_trq;
          trq_duty_o <= is_duty;
        end
        default: begin
          trq_o      <= ramp_trq;
          trq_duty_o <= is_duty;
        end
      endcase
    end
  end

endmodule

// File: rtl/fcs_startup_seq.sv
module fcs_startup_seq
  import fcs_pkg::*;
#(
  parameter int PHASES      = 6,
  parameter int HOLD_BASE   = 10,
  parameter int HOLD_UNIT   = 40,
  parameter int START_UNIT  = 40,
  parameter int END_UNIT    = 1,
  parameter int STEP_UNIT   = 1,
  localparam int PH_W       = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [CFG_W-1:0] hold_time_i,
  input  logic [CFG_W-1:0] hold_trq_i,
  input  logic [CFG_W-1:0] ramp_trq_i,
  input  logic             trq_is_duty_i,
  input  logic [CFG_W-1:0] start_per_i,
  input  logic [CFG_W-1:0] end_per_i,
  input  logic [CFG_W-1:0] step_i,
  output logic [1:0]       state_o,
  output logic [PH_W-1:0]  phase_o,
  output logic [CFG_W-1:0] trq_o,
  output logic             trq_duty_o,
  output logic             done_o
);

  localparam int FMAX      = (1 << CFG_W) - 1;
  localparam int HOLD_MAX  = HOLD_BASE + FMAX * HOLD_UNIT;
  localparam int START_MAX = FMAX * START_UNIT;
  localparam int END_MAX   = FMAX * END_UNIT;
  localparam int MAX_A     = (HOLD_MAX > START_MAX) ? HOLD_MAX : START_MAX;
  localparam int MAX_T     = (MAX_A > END_MAX) ? MAX_A : END_MAX;
  localparam int CNT_W     = $clog2(MAX_T + 1);

  fcs_state_e state_q, state_nxt;
  fcs_cfg_t   cfg_q, cfg_d, cfg_in;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] hold_len, start_len, end_len, step_len, tmr_limit;
  logic [CNT_W:0]   last_thresh;
  logic             skip_ramp, last_interval, tmr_exp, tmr_run, tmr_clr;
  logic             ph_adv, ph_clr, cfg_load;

  // configuration capture
  assign cfg_in = '{hold_time: hold_time_i, hold_trq: hold_trq_i,
                    ramp_trq:  ramp_trq_i,  start_per: start_per_i,
                    end_per:   end_per_i,   step: step_i,
                    is_duty:   trq_is_duty_i};
  assign cfg_load = (state_q == ST_IDLE) && start_i;
  assign cfg_d    = cfg_load ? cfg_in : cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  // derived interval lengths in ticks
  assign hold_len  = CNT_W'(HOLD_BASE) + CNT_W'(cfg_q.hold_time) * CNT_W'(HOLD_UNIT);
  assign start_len = CNT_W'(cfg_q.start_per) * CNT_W'(START_UNIT);
  assign end_len   = CNT_W'(cfg_q.end_per) * CNT_W'(END_UNIT);
  assign step_len  = CNT_W'(cfg_q.step) * CNT_W'(STEP_UNIT);

  assign skip_ramp     = (step_len == '0) || (start_len <= end_len);
  assign last_thresh   = {1'b0, end_len} + {1'b0, step_len};
  assign last_interval = ({1'b0, period_q} <= last_thresh);

  // state transitions
  always_comb begin
    state_nxt = state_q;
    if (!start_i) begin
      state_nxt = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_nxt = ST_HOLD;
        ST_HOLD: if (tmr_exp) state_nxt = skip_ramp ? ST_DONE : ST_RAMP;
        ST_RAMP: if (tmr_exp && last_interval) state_nxt = ST_DONE;
        default: state_nxt = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_nxt;
    end
  end

  // commutation interval register
  always_ff @(posedge clk) begin
    if (rst || !start_i) begin
      period_q <= '0;
    end else if (state_q == ST_HOLD && tmr_exp) begin
      period_q <= skip_ramp ? end_len : start_len;
    end else if (state_q == ST_RAMP && tmr_exp) begin
      period_q <= last_interval ? end_len : period_q - step_len;
    end
  end

  // interval timer
  assign tmr_run   = tick_i && start_i && (state_q == ST_HOLD || state_q == ST_RAMP);
  assign tmr_clr   = (state_nxt != state_q);
  assign tmr_limit = (state_q == ST_HOLD) ? hold_len : period_q;

  fcs_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clr      (tmr_clr),
    .run      (tmr_run),
    .limit    (tmr_limit),
    .expire_o (tmr_exp)
  );

  // commutation step
  assign ph_adv = (state_q == ST_RAMP) && start_i && tmr_exp;
  assign ph_clr = (state_nxt == ST_IDLE);

  fcs_phase_ctr #(.PHASES(PHASES)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .clr     (ph_clr),
    .adv     (ph_adv),
    .phase_o (phase_o)
  );

  // torque demand and done flag
  fcs_torque_out u_trq (
    .clk        (clk),
    .rst        (rst),
    .state_nxt  (state_nxt),
    .hold_trq   (cfg_d.hold_trq),
    .ramp_trq   (cfg_d.ramp_trq),
    .is_duty    (cfg_d.is_duty),
    .trq_o      (trq_o),
    .trq_duty_o (trq_duty_o),
    .done_o     (done_o)
  );

  assign state_o = state_q;

endmodule

// File: rtl/fcs_startup_seq_chk.sv
module fcs_startup_seq_chk #(
  parameter int PHASES = 6,
  parameter int PH_W   = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic            tick_i,
  input logic [1:0]      state_o,
  input logic [PH_W-1:0] phase_o,
  input logic [3:0]      trq_o,
  input logic            trq_duty_o,
  input logic            done_o
);

  // R6
  done_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done_o == (state_o == 2'd3));

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(phase_o) < PHASES);

  // R4
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o != $past(phase_o)) |->
      (phase_o == '0 || int'(phase_o) == int'($past(phase_o)) + 1));

  // R6
  phase_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd3 && start_i) |=> $stable(phase_o));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> (state_o == 2'd0 && phase_o == '0 && !done_o));

  // R8
  idle_trq_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0) |-> (trq_o == '0 && !trq_duty_o));

  // R10
  no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !tick_i && state_o != 2'd0) |=> ($stable(state_o) && $stable(phase_o)));

  // R2
  start_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0 && start_i) |=> (state_o == 2'd1));

endmodule

bind fcs_startup_seq fcs_startup_seq_chk #(.PHASES(PHASES), .PH_W(PH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .tick_i     (tick_i),
  .state_o    (state_o),
  .phase_o    (phase_o),
  .trq_o      (trq_o),
  .trq_duty_o (trq_duty_o),
  .done_o     (done_o)
);

// File: tb/test_fcs_startup_seq.sv
module test_fcs_startup_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic tick_i = 1'b0;
  logic [3:0] hold_time_i = '0, hold_trq_i = '0, ramp_trq_i = '0;
  logic [3:0] start_per_i = '0, end_per_i = '0, step_i = '0;
  logic trq_is_duty_i = 1'b0;
  logic [1:0] state_o;
  logic [2:0] phase_o;
  logic [3:0] trq_o;
  logic trq_duty_o, done_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_mode = 0; // 0 every cycle, 1 alternate, 2 stalled
  bit finished = 0;

  fcs_startup_seq i_fcs_startup_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .tick_i(tick_i),
    .hold_time_i(hold_time_i), .hold_trq_i(hold_trq_i), .ramp_trq_i(ramp_trq_i),
    .trq_is_duty_i(trq_is_duty_i), .start_per_i(start_per_i),
    .end_per_i(end_per_i), .step_i(step_i),
    .state_o(state_o), .phase_o(phase_o), .trq_o(trq_o),
    .trq_duty_o(trq_duty_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // timebase driver
  always @(negedge clk) begin
    case (tick_mode)
      0: tick_i <= 1'b1;
      1: tick_i <= ~tick_i;
      default: tick_i <= 1'b0;
    endcase
  end

  // behavioural reference model
  int m_st, m_cnt, m_ph, m_per, m_trq, m_duty;
  int c_ht, c_hq, c_rq, c_sc, c_ec, c_rr, c_md;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_ph = 0; m_per = 0;
    end else if (!start_i) begin
      m_st = 0; m_cnt = 0; m_ph = 0; m_per = 0;
    end else begin
      case (m_st)
        0: begin
          c_ht = hold_time_i; c_hq = hold_trq_i; c_rq = ramp_trq_i;
          c_sc = start_per_i; c_ec = end_per_i; c_rr = step_i; c_md = trq_is_duty_i;
          m_st = 1; m_cnt = 0;
        end
        1: if (tick_i) begin
          if (m_cnt + 1 == 10 + 40 * c_ht) begin
            m_cnt = 0;
            if (c_rr == 0 || 40 * c_sc <= c_ec) m_st = 3;
            else begin m_st = 2; m_per = 40 * c_sc; end
          end else m_cnt++;
        end
        2: if (tick_i) begin
          if (m_cnt + 1 == m_per) begin
            m_cnt = 0;
            m_ph = (m_ph + 1) % 6;
            if (m_per - c_rr <= c_ec) begin m_st = 3; m_per = c_ec; end
            else m_per = m_per - c_rr;
          end else m_cnt++;
        end
        default: ;
      endcase
    end
    m_trq  = (m_st == 0) ? 0 : (m_st == 1) ? c_hq : c_rq;
    m_duty = (m_st == 0) ? 0 : c_md;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (int'(state_o) != m_st || int'(phase_o) != m_ph || int'(trq_o) != m_trq ||
          int'(trq_duty_o) != m_duty || done_o != (m_st == 3)) begin
        errors++;
        $display("FAIL R3 R5 R8 R10 model: st=%0d ph=%0d trq=%0d duty=%0d done=%0d exp st=%0d ph=%0d trq=%0d duty=%0d",
                 state_o, phase_o, trq_o, trq_duty_o, done_o, m_st, m_ph, m_trq, m_duty);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic setcfg(input int ht, hq, rq, md, sc, ec, rr);
    hold_time_i = 4'(ht); hold_trq_i = 4'(hq); ramp_trq_i = 4'(rq);
    trq_is_duty_i = md[0]; start_per_i = 4'(sc); end_per_i = 4'(ec); step_i = 4'(rr);
  endtask

  // edges from start until done seen; -1 on timeout
  task automatic run_to_done(input int maxc, output int n);
    n = 0;
    while (!done_o && n < maxc) begin
      @(negedge clk);
      n++;
    end
    if (!done_o) n = -1;
  endtask

  function automatic int ramp_ticks(input int sc, ec, rr, output int adv);
    int p = 40 * sc;
    int tot = 0;
    adv = 0;
    forever begin
      tot += p; adv++;
      if (p - rr <= ec) break;
      p -= rr;
    end
    return tot;
  endfunction

  initial begin
    int n, adv, exp_n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(state_o == 2'd0 && phase_o == 0 && trq_o == 0 && !trq_duty_o && !done_o,
        "R1 reset", int'(state_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(state_o == 2'd0 && !done_o, "R1 after reset", int'(state_o), 0);

    // Scenario A: short hold, ramp ending by clamp
    setcfg(0, 9, 12, 1, 2, 5, 15);
    start_i = 1'b1;
    @(negedge clk);
    chk(state_o == 2'd1, "R2 hold entry", int'(state_o), 1);
    chk(trq_o == 4'd9 && trq_duty_o, "R8 hold torque", int'(trq_o), 9);
    setcfg(15, 1, 1, 0, 15, 0, 1); // R11: must be ignored
    run_to_done(5000, n);
    exp_n = 10 + ramp_ticks(2, 5, 15, adv);
    chk(n + 1 == 1 + exp_n, "R3 R4 R5 R6 R11 duration", n + 1, 1 + exp_n);
    chk(int'(phase_o) == adv % 6, "R6 final step", int'(phase_o), adv % 6);
    chk(trq_o == 4'd12 && trq_duty_o, "R8 R11 done torque", int'(trq_o), 12);
    repeat (20) @(negedge clk);
    chk(int'(phase_o) == adv % 6 && done_o, "R6 frozen", int'(phase_o), adv % 6);

    // R9: abort from finished
    start_i = 1'b0;
    @(negedge clk);
    chk(state_o == 2'd0 && phase_o == 0 && trq_o == 0 && !done_o, "R9 abort", int'(state_o), 0);

    // Scenario B: wrap of step counter, current mode, alternating ticks
    setcfg(1, 3, 6, 0, 1, 3, 7);
    tick_mode = 1;
    start_i = 1'b1;
    @(negedge clk);
    chk(state_o == 2'd1 && trq_o == 4'd3 && !trq_duty_o, "R2 R8 current-mode hold", int'(trq_o), 3);
    run_to_done(5000, n);
    void'(ramp_ticks(1, 3, 7, adv));
    chk(n > 0 && int'(phase_o) == adv % 6, "R4 wrap to step 0", int'(phase_o), adv % 6);
    start_i = 1'b0;
    tick_mode = 0;
    @(negedge clk);

    // R10: stalled ticks inside hold, then abort mid ramp
    setcfg(0, 5, 7, 1, 3, 1, 2);
    start_i = 1'b1;
    repeat (4) @(negedge clk);
    tick_mode = 2;
    repeat (60) @(negedge clk);
    chk(state_o == 2'd1, "R10 stalled hold", int'(state_o), 1);
    tick_mode = 0;
    repeat (60) @(negedge clk);
    chk(state_o == 2'd2, "R3 ramp after hold", int'(state_o), 2);
    chk(phase_o == 3'd0, "R4 first interval spans 120 ticks", int'(phase_o), 0);
    repeat (100) @(negedge clk);
    chk(phase_o == 3'd1, "R4 R5 advance", int'(phase_o), 1);
    start_i = 1'b0;
    @(negedge clk);
    chk(state_o == 2'd0 && phase_o == 0, "R9 abort in ramp", int'(state_o), 0);

    // R7: zero decrement skips ramp
    setcfg(0, 2, 4, 0, 5, 0, 0);
    start_i = 1'b1;
    repeat (11) @(negedge clk);
    chk(state_o == 2'd3 && phase_o == 0 && done_o, "R7 zero decrement", int'(state_o), 3);
    start_i = 1'b0;
    @(negedge clk);
    // R7: start interval no longer than end
    setcfg(0, 2, 4, 1, 0, 9, 3);
    start_i = 1'b1;
    repeat (11) @(negedge clk);
    chk(state_o == 2'd3 && phase_o == 0, "R7 short start interval", int'(state_o), 3);
    start_i = 1'b0;
    repeat (2) @(negedge clk);

    finish_run();
  end

endmodule